// File: doc/BRIEF.md
# Dual-Core Power-Down Sequencer

This block coordinates sleep and wake for two processor cores that run from one shared clock generator. A host writes a two-bit command to a per-core control word. Bit 0 asks the core to sleep and bit 1 asks it to wake. The block sends the core a power-down interrupt or a wake pulse. It follows the core's "inside handler" and "IDLE executed" signals, and it turns the shared clock generator off only while both cores are asleep. The generator comes back on as soon as either core is woken.

Readback merges two things: the core's handler position and whether the shared clock is usable. The clock counts as usable only when three conditions hold: the enable is on, the generator reports lock, and a fixed settling window has passed since the enable came on. While it is not usable, every core's memory-access block stays asserted, so software polls the sleep bit until it reads 0.

Each core runs one state machine with five states. RUN is normal operation. REQ means the interrupt was sent and the core has not yet entered its handler. HANDLER means the core is in the handler but has not reached IDLE. SLEEP means the core is in the handler after IDLE and counts as powered down. WAKE means a wake pulse was sent and the block waits for the core to leave the handler. The transitions are:
- RUN→REQ on a sleep command.
- REQ→HANDLER when the handler flag is seen.
- HANDLER→SLEEP on IDLE.
- HANDLER→RUN if the core leaves the handler without reaching IDLE.
- HANDLER→WAKE on a wake command, which aborts the power-down.
- SLEEP→WAKE on a wake command.
- WAKE→RUN when the core leaves the handler.
- WAKE→REQ when the core leaves the handler and a sleep command was stored. This re-issues the interrupt and aborts the power-up.

Top module: `pdseq_ctrl`

## Requirements
- R1: While reset is held, and right after it is released, the block is in this state: no interrupt or wake pulse, clock enable high, every memory block high, and the sleep bit of the readback at 1. Every core starts in RUN with no stored sleep command.
- R2: A write with data 2'b01 to a core in RUN produces exactly one power-down interrupt pulse to that core, in the cycle after the write. The target core is selected by host_wr_sel.
- R3: A write of 2'b00 has no effect. A write of 2'b11 acts as a wake command only, and never produces a power-down interrupt.
- R4: A wake command to a core in HANDLER produces one wake pulse. That core is then never counted as powered down, so the shared clock stays on.
- R5: A wake command to a core in SLEEP produces one wake pulse in the next cycle. The clock enable is high again in that same cycle.
- R6: A sleep command to a core in SLEEP or WAKE is stored. When that core then leaves its handler, it receives a fresh interrupt pulse in the following cycle.
- R7: Readback bit 1 equals the selected core's in-handler input.
- R8: Readback bit 0 is 1 when the selected core is in SLEEP or when the shared clock is not usable. Otherwise it is 0.
- R9: The clock enable is low exactly while both cores are in SLEEP.
- R10: The clock is usable only when three conditions hold: the enable is high, clkgen_locked is high, and LOCK_DELAY (default 4) clock edges have passed with the enable high. mem_block for a core equals that core's readback bit 0.
- R11: Interrupt and wake pulses last one cycle. No core ever receives both pulses in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_wr_sel | input | SEL_W | Core addressed by the write |
| host_wr_data | input | 2 | Bit 0 sleep command, bit 1 wake command |
| host_rd_sel | input | SEL_W | Core addressed by the readback |
| host_rd_data | output | 2 | Bit 0 powered-down/clock-not-ready, bit 1 in handler |
| core_in_handler | input | N | Core is inside its power-down handler |
| core_idle_done | input | N | Core has executed IDLE in the handler |
| core_pd_irq | output | N | Power-down interrupt pulse |
| core_wake | output | N | Wake pulse |
| clkgen_en | output | 1 | Shared clock generator enable |
| clkgen_locked | input | 1 | Clock generator reports stable |
| mem_block | output | N | Memory access blocked per core |

## Verification
Interrupt and wake pulses come from registers. A write or handler change driven before edge k shows up on the pulse outputs after edge k and lasts one cycle. The clock enable is decoded from the state registers, so it changes after the same edge. The usable-clock qualifier lags by LOCK_DELAY further edges, which means mem_block falls on the fourth edge after the enable rises. Readback is combinational. The bench drives inputs on the falling edge and samples one falling edge later, so exactly one rising edge lies between stimulus and check. Readback is checked 1 ns after it is driven, and the settling window is checked on both sides of its last edge.

// File: rtl/pdseq_pkg.sv
`timescale 1ns/1ps
package pdseq_pkg;

    typedef enum logic [2:0] {
        CS_RUN     = 3'd0,
        CS_REQ     = 3'd1,
        CS_HANDLER = 3'd2,
        CS_SLEEP   = 3'd3,
        CS_WAKE    = 3'd4
    } core_st_e;

    // Decoded command for one core after priority resolution
    typedef struct packed {
        logic pd;
        logic pu;
    } host_cmd_t;

endpackage

// File: rtl/pdseq_host_if.sv
`timescale 1ns/1ps
module pdseq_host_if
    import pdseq_pkg::*;
#(
    parameter int N     = 2,
    parameter int SEL_W = 1
) (
    input  logic                 host_wr,
    input  logic [SEL_W-1:0]     host_wr_sel,
    input  logic [1:0]           host_wr_data,
    input  logic [SEL_W-1:0]     host_rd_sel,
    input  logic [N-1:0]         in_handler,
    input  logic [N-1:0]         sleeping,
    input  logic                 clk_ok,
    output host_cmd_t [N-1:0]    cmd,
    output logic [1:0]           host_rd_data
);

    // Wake has priority: a sleep command is dropped when both bits are set
    for (genvar i = 0; i < N; i++) begin : g_dec
        logic hit;
        assign hit       = host_wr && (host_wr_sel == SEL_W'(i));
        assign cmd[i].pu = hit && host_wr_data[1];
        assign cmd[i].pd = hit && host_wr_data[0] && !host_wr_data[1];
    end

    always_comb begin
        host_rd_data = 2'b01;
        if (int'(host_rd_sel) < N) begin
            host_rd_data[1] = in_handler[host_rd_sel];
            host_rd_data[0] = sleeping[host_rd_sel] | ~clk_ok;
        end
    end

endmodule

// File: rtl/pdseq_core_fsm.sv
`timescale 1ns/1ps
module pdseq_core_fsm
    import pdseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  host_cmd_t cmd,
    input  logic      in_handler,
    input  logic      idle_done,
    output logic      pd_irq,
    output logic      wake,
    output logic      sleeping
);

    core_st_e st_q, st_nx;
    logic     again_q;
    logic     irq_set, wake_set, again_set, again_clr;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CS_RUN;
        else        st_q <= st_nx;
    end

    // Next state and pulse requests
    always_comb begin
        st_nx     = st_q;
        irq_set   = 1'b0;
        wake_set  = 1'b0;
        again_set = 1'b0;
        again_clr = 1'b0;
        unique case (st_q)
            CS_RUN: begin
                if (cmd.pd) begin
                    st_nx   = CS_REQ;
                    irq_set = 1'b1;
                end
            end
            CS_REQ: begin
                if (in_handler) st_nx = CS_HANDLER;
            end
            CS_HANDLER: begin
                if (cmd.pu) begin
                    st_nx    = CS_WAKE;     // pass through IDLE, clocks kept
                    wake_set = 1'b1;
                end else if (idle_done) begin
                    st_nx = CS_SLEEP;
                end else if (!in_handler) begin
                    st_nx = CS_RUN;
                end
            end
            CS_SLEEP: begin
                if (cmd.pu) begin
                    st_nx    = CS_WAKE;
                    wake_set = 1'b1;
                end else if (cmd.pd) begin
                    again_set = 1'b1;
                end
            end
            CS_WAKE: begin
                if (cmd.pd) again_set = 1'b1;
                if (!in_handler) begin
                    again_clr = 1'b1;
                    if (again_q || cmd.pd) begin
                        st_nx   = CS_REQ;     // power-up aborted
                        irq_set = 1'b1;
                    end else begin
                        st_nx = CS_RUN;
                    end
                end
            end
            default: st_nx = CS_RUN;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pd_irq  <= 1'b0;
            wake    <= 1'b0;
            again_q <= 1'b0;
        end else begin
            pd_irq <= irq_set;
            wake   <= wake_set;
            if (again_clr)      again_q <= 1'b0;
            else if (again_set) again_q <= 1'b1;
        end
    end

    assign sleeping = (st_q == CS_SLEEP);

endmodule

// File: rtl/pdseq_clk_ctrl.sv
`timescale 1ns/1ps
module pdseq_clk_ctrl #(
    parameter int N          = 2,
    parameter int LOCK_DELAY = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sleeping,
    input  logic         locked,
    output logic         en,
    output logic         clk_ok
);

    localparam int          CW  = $clog2(LOCK_DELAY + 1);
    localparam logic [CW-1:0] LIM = CW'(LOCK_DELAY);

    logic [CW-1:0] settle_q;

    assign en = ~(&sleeping);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             settle_q <= '0;
        else if (!en)           settle_q <= '0;
        else if (settle_q != LIM) settle_q <= settle_q + 1'b1;
    end

    assign clk_ok = en & locked & (settle_q == LIM);

endmodule

// File: rtl/pdseq_ctrl.sv
`timescale 1ns/1ps
module pdseq_ctrl
    import pdseq_pkg::*;
#(
    parameter int N          = 2,
    parameter int LOCK_DELAY = 4,
    localparam int SEL_W     = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic [SEL_W-1:0] host_wr_sel,
    input  logic [1:0]       host_wr_data,
    input  logic [SEL_W-1:0] host_rd_sel,
    output logic [1:0]       host_rd_data,
    input  logic [N-1:0]     core_in_handler,
    input  logic [N-1:0]     core_idle_done,
    output logic [N-1:0]     core_pd_irq,
    output logic [N-1:0]     core_wake,
    output logic             clkgen_en,
    input  logic             clkgen_locked,
    output logic [N-1:0]     mem_block
);

    host_cmd_t [N-1:0] cmd;
    logic [N-1:0]      sleeping;
    logic              clk_ok;

    pdseq_host_if #(.N(N), .SEL_W(SEL_W)) host_i (
        .host_wr      (host_wr),
        .host_wr_sel  (host_wr_sel),
        .host_wr_data (host_wr_data),
        .host_rd_sel  (host_rd_sel),
        .in_handler   (core_in_handler),
        .sleeping     (sleeping),
        .clk_ok       (clk_ok),
        .cmd          (cmd),
        .host_rd_data (host_rd_data)
    );

    for (genvar i = 0; i < N; i++) begin : g_core
        pdseq_core_fsm core_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .cmd        (cmd[i]),
            .in_handler (core_in_handler[i]),
            .idle_done  (core_idle_done[i]),
            .pd_irq     (core_pd_irq[i]),
            .wake       (core_wake[i]),
            .sleeping   (sleeping[i])
        );
        assign mem_block[i] = sleeping[i] | ~clk_ok;
    end

    pdseq_clk_ctrl #(.N(N), .LOCK_DELAY(LOCK_DELAY)) clkc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleeping (sleeping),
        .locked   (clkgen_locked),
        .en       (clkgen_en),
        .clk_ok   (clk_ok)
    );

endmodule

// File: rtl/pdseq_chk.sv
`timescale 1ns/1ps
module pdseq_chk #(
    parameter int N = 2
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] core_pd_irq,
    input logic [N-1:0] core_wake,
    input logic         clkgen_en,
    input logic         clkgen_locked,
    input logic [N-1:0] mem_block
);

    // R11
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(core_pd_irq & $past(core_pd_irq))));

    // R11
    wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(core_wake & $past(core_wake))));

    // R11
    irq_wake_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(core_pd_irq & core_wake)));

    // R9
    clk_off_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clkgen_en |-> &mem_block);

    // R10
    unlocked_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clkgen_locked |-> &mem_block);

    // R10
    restart_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clkgen_en) |-> &mem_block);

endmodule

bind pdseq_ctrl pdseq_chk #(.N(N)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .core_pd_irq   (core_pd_irq),
    .core_wake     (core_wake),
    .clkgen_en     (clkgen_en),
    .clkgen_locked (clkgen_locked),
    .mem_block     (mem_block)
);

// File: tb/pdseq_ctrl_tb_top.sv
`timescale 1ns/1ps
module pdseq_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic [0:0] host_wr_sel = '0;
    logic [1:0] host_wr_data = '0;
    logic [0:0] host_rd_sel = '0;
    logic [1:0] host_rd_data;
    logic [1:0] core_in_handler = '0;
    logic [1:0] core_idle_done = '0;
    logic [1:0] core_pd_irq;
    logic [1:0] core_wake;
    logic       clkgen_en;
    logic       clkgen_locked = 1'b1;
    logic [1:0] mem_block;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pdseq_ctrl dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .host_wr         (host_wr),
        .host_wr_sel     (host_wr_sel),
        .host_wr_data    (host_wr_data),
        .host_rd_sel     (host_rd_sel),
        .host_rd_data    (host_rd_data),
        .core_in_handler (core_in_handler),
        .core_idle_done  (core_idle_done),
        .core_pd_irq     (core_pd_irq),
        .core_wake       (core_wake),
        .clkgen_en       (clkgen_en),
        .clkgen_locked   (clkgen_locked),
        .mem_block       (mem_block)
    );

    // {wr, sel, data[1:0], hnd[1:0], idl[1:0], lck | irq[1:0], wake[1:0], en, mblk[1:0]}
    localparam int NV = 20;
    localparam logic [15:0] VEC [NV] = '{
        16'b1_0_01_00_00_1_01_00_1_00, // R2 core0 sleep command
        16'b0_0_00_01_00_1_00_00_1_00, // R11 pulse gone, core0 in handler
        16'b0_0_00_01_01_1_00_00_1_01, // core0 IDLE -> asleep
        16'b1_1_01_01_01_1_10_00_1_01, // R2 core1 sleep command
        16'b0_0_00_11_01_1_00_00_1_01,
        16'b0_0_00_11_11_1_00_00_0_11, // R9 both asleep, clock off
        16'b1_0_10_11_11_1_00_01_1_11, // R5 wake core0, enable back
        16'b0_0_00_10_10_1_00_00_1_11, // R10 settling edge 1
        16'b0_0_00_10_10_1_00_00_1_11, // settling edge 2
        16'b0_0_00_10_10_1_00_00_1_11, // settling edge 3
        16'b0_0_00_10_10_1_00_00_1_10, // settling edge 4, clock usable
        16'b1_1_01_10_10_1_00_00_1_10, // R6 sleep stored on sleeping core1
        16'b1_1_10_10_10_1_00_10_1_00, // wake core1
        16'b0_0_00_00_00_1_10_00_1_00, // R6 core1 leaves, re-interrupted
        16'b1_0_11_00_00_1_00_00_1_00, // R3 both bits, no interrupt
        16'b1_0_00_00_00_1_00_00_1_00, // R3 zero write
        16'b0_0_00_10_00_1_00_00_1_00, // core1 enters handler
        16'b1_1_10_10_00_1_00_10_1_00, // R4 wake before IDLE
        16'b0_0_00_10_10_1_00_00_1_00, // R4 passes IDLE, clock stays on
        16'b0_0_00_00_00_1_00_00_1_00
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [8:0] s);
        host_wr         = s[8];
        host_wr_sel     = s[7];
        host_wr_data    = s[6:5];
        core_in_handler = s[4:3];
        core_idle_done  = s[2:1];
        clkgen_locked   = s[0];
    endtask

    initial begin : watchdog
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 pulses", {4'b0, core_pd_irq, core_wake}, 8'h00);
        chk("R1 enable/block", {5'b0, clkgen_en, mem_block}, {5'b0, 3'b111});
        chk("R1 readback", {6'b0, host_rd_data}, 8'h01);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            drive(VEC[k][15:7]);
            @(negedge clk);
            chk($sformatf("R2 R11 irq step %0d", k), {6'b0, core_pd_irq}, {6'b0, VEC[k][6:5]});
            chk($sformatf("R5 wake step %0d", k), {6'b0, core_wake}, {6'b0, VEC[k][4:3]});
            chk($sformatf("R9 enable step %0d", k), {7'b0, clkgen_en}, {7'b0, VEC[k][2]});
            chk($sformatf("R10 mem_block step %0d", k), {6'b0, mem_block}, {6'b0, VEC[k][1:0]});
        end

        // R7 R8 readback: core0 to handler, then asleep
        drive(9'b1_0_01_00_00_1);
        @(negedge clk);
        drive(9'b0_0_00_01_00_1);
        @(negedge clk);
        host_rd_sel = 1'b0;
        #1;
        chk("R7 handler pre-IDLE readback", {6'b0, host_rd_data}, 8'h02);
        drive(9'b0_0_00_01_01_1);
        @(negedge clk);
        #1;
        chk("R8 asleep readback", {6'b0, host_rd_data}, 8'h03);
        host_rd_sel = 1'b1;
        #1;
        chk("R7 R8 other core readback", {6'b0, host_rd_data}, 8'h00);

        // R10 lock lost
        clkgen_locked = 1'b0;
        #1;
        chk("R10 unlocked readback", {6'b0, host_rd_data}, 8'h01);
        chk("R10 unlocked mem_block", {6'b0, mem_block}, 8'h03);
        clkgen_locked = 1'b1;
        #1;
        chk("R10 relocked mem_block", {6'b0, mem_block}, 8'h01);

        // R1 reset again, then settling window
        @(negedge clk);
        drive(9'b0_0_00_00_00_1);
        rst_n = 1'b0;
        host_rd_sel = 1'b0;
        #1;
        chk("R1 reset mem_block", {6'b0, mem_block}, 8'h03);
        chk("R1 reset readback", {6'b0, host_rd_data}, 8'h01);
        chk("R1 reset enable", {7'b0, clkgen_en}, 8'h01);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 window edge 3", {6'b0, mem_block}, 8'h03);
        @(negedge clk);
        chk("R10 window edge 4", {6'b0, mem_block}, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule